// File: doc/BRIEF.md
# Four-Channel DMA Register and Sequencing Front End

This block holds the programmable state of a small DMA engine and steps each channel through its transfer. Software reaches it through a word-wide register port. Each channel has the following programmable state:

- a mode word (transfer width and trigger source);
- source and destination addresses;
- a byte count;
- a control word (enable, clear-enable-on-end, request).

A global start bit, a shared activity status word and a shared sticky error word complete the map.

A channel begins when four things hold at once: it is enabled, the global start bit is set, its request bit is set and its count is non-zero. At that point its addresses and count are checked against the alignment that the width demands. A misaligned or invalid setting raises the channel's error flag instead of starting the transfer. Running channels compete for a single memory-side beat port, and the lowest index wins. On each acknowledged beat the owning channel moves both addresses forward by the beat width and lowers the count by the same amount. When the count reaches zero the transfer ends.

Top module: `dma_ctl_unit`

## Requirements
- R1: Register map. Channel c sits at base c*0x20. The words are: +0x00 mode (bits 2:0 width code, bit 4 software-trigger select), +0x04 source, +0x08 destination, +0x0C count, +0x10 control (bit 0 enable, bit 1 clear-enable-on-end, bit 2 request). Global words are 0x80 start (bit 0), 0x84 status (bit c = channel c active, read-only) and 0x88 error (bit c per channel). Writes need reg_addr[1:0]=0. After reset every register reads 0 and mem_req is 0.
- R2: Width codes are 000 for 1 byte, 001 for 2 bytes and 010 for 4 bytes. Each accepted beat adds the width to source and destination and subtracts it from the count.
- R3: Alignment is checked when a channel tries to start. Width 001 needs bit 0 of source, destination and count to be 0. Width 010 needs bits 1:0 of all three to be 0. Width 000 accepts any value. Any other code fails the check. A failing check sets the channel's error bit, clears its enable and leaves it inactive.
- R4: The status bit falls in the cycle after the final beat is acknowledged, so a count of N bytes at width w gives exactly N/w beats. If clear-enable-on-end is 1 the enable reads 0 afterwards; if it is 0 the enable stays 1.
- R5: With software trigger off, the request bit is hw_req registered by one clock, and software writes to it have no effect. With software trigger on, hw_req is ignored, the request bit takes the value written to control bit 2, and it is cleared when the channel starts.
- R6: The status bit rises one cycle after enable, start, request and a non-zero count all hold together with a passing alignment check.
- R7: Error bits are sticky. Writing 1 to bit c of the error word clears channel c. Bits written as 0 keep their value. A new error in the same cycle wins over the clear.
- R8: Writes to mode, source, destination and count are ignored while the channel is active, or while its enable and the global start bit are both 1.
- R9: Writes to mode, source, destination and count with reg_be other than 4'hF are ignored.
- R10: With several channels active, the lowest index owns the memory port (mem_ch, mem_src, mem_dst, mem_size). mem_ack advances only that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hw_req | input | NCH | Hardware transfer requests, one per channel |
| mem_req | output | 1 | A beat is offered on the memory side |
| mem_ch | output | CHW | Channel owning the offered beat |
| mem_src | output | 32 | Source address of the beat |
| mem_dst | output | 32 | Destination address of the beat |
| mem_size | output | 3 | Width code of the beat |
| mem_ack | input | 1 | Memory side accepts the offered beat |

## Verification
The bench builds the block with its default of four channels. This lets one vector table cover every channel index, every width code (one of them invalid) and both settings of the end-clear option. Having four channels also lets two channels run at once, so the priority on the shared memory port can be observed. Directed tests then cover the register lock, partial-byte writes, both request modes and the write-one-to-clear error word.

// File: rtl/dma_ctl_pkg.sv
// Package: shared encodings and register offsets for the DMA front end.
// Assumes a 32-bit register port and at most four channels in the map.
package dma_ctl_pkg;
    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'b000,
        SZ_HALF = 3'b001,
        SZ_WORD = 3'b010
    } xfer_size_e;

    // word offsets inside a channel window
    localparam logic [2:0] OFF_MODE = 3'd0;
    localparam logic [2:0] OFF_SRC  = 3'd1;
    localparam logic [2:0] OFF_DST  = 3'd2;
    localparam logic [2:0] OFF_CNT  = 3'd3;
    localparam logic [2:0] OFF_CTRL = 3'd4;

    // word offsets inside the global window
    localparam logic [1:0] GOFF_START  = 2'd0;
    localparam logic [1:0] GOFF_STATUS = 2'd1;
    localparam logic [1:0] GOFF_ERR    = 2'd2;
endpackage

// File: rtl/dma_align_chk.sv
// Alignment checker: decodes the width code into a beat step and reports
// whether source, destination and count satisfy that width's alignment.
// Assumes the operands are full register words; invalid codes never pass.
module dma_align_chk
    import dma_ctl_pkg::*;
(
    input  logic [2:0]       size_code,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] cnt,
    output logic [2:0]       step,
    output logic             ok
);
    logic [1:0] low_or;

    // Collect the low two bits of all three operands.
    always_comb begin
        low_or = src[1:0] | dst[1:0] | cnt[1:0];
    end

    // Decode the step and the alignment verdict.
    always_comb begin
        case (size_code)
            SZ_BYTE: begin step = 3'd1; ok = 1'b1;          end
            SZ_HALF: begin step = 3'd2; ok = !low_or[0];    end
            SZ_WORD: begin step = 3'd4; ok = (low_or == 2'b00); end
            default: begin step = 3'd1; ok = 1'b0;          end
        endcase
    end
endmodule

// File: rtl/dma_beat_arb.sv
// Fixed-priority arbiter for the shared memory beat port: the lowest set
// request wins. Assumes NCH >= 2 so the index has at least one bit.
module dma_beat_arb #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] want,
    output logic [NCH-1:0] grant,
    output logic [CHW-1:0] idx,
    output logic           any
);
    // Isolate the lowest set request bit.
    always_comb begin
        grant = want & (~want + NCH'(1));
        any   = |want;
    end

    // Encode the winning bit into an index.
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (want[i]) idx = CHW'(i);
        end
    end

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10
    grant_follows_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (grant != '0));
endmodule

// File: rtl/dma_chan_core.sv
// One DMA channel: holds the mode, address, count and control registers,
// applies the write lock, qualifies the start, and steps the transfer on
// each accepted beat. Assumes the top decodes the channel window and only
// raises beat_ok for the channel that owns the memory port.
module dma_chan_core
    import dma_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_off,
    input  logic [3:0]       wr_be,
    input  logic [REG_W-1:0] wr_data,
    input  logic             go,
    input  logic             hw_req,
    input  logic             beat_ok,
    input  logic [2:0]       rd_off,
    output logic [REG_W-1:0] rd_data,
    output logic             active,
    output logic             err_pulse,
    output logic [REG_W-1:0] src_addr,
    output logic [REG_W-1:0] dst_addr,
    output logic [2:0]       size_code
);
    logic [2:0]       size_q;
    logic             sw_q;
    logic [REG_W-1:0] src_q, dst_q, cnt_q;
    logic             en_q, eclr_q, req_q, act_q;

    logic [2:0]       step;
    logic             aligned;
    logic             unlocked, cfg_wr, ctrl_wr, start_try, last_beat;
    logic [REG_W-1:0] step_w;

    dma_align_chk u_align (
        .size_code (size_q),
        .src       (src_q),
        .dst       (dst_q),
        .cnt       (cnt_q),
        .step      (step),
        .ok        (aligned)
    );

    // Qualify register writes, start attempts and the final beat.
    always_comb begin
        step_w    = {{(REG_W-3){1'b0}}, step};
        unlocked  = !act_q && (!en_q || !go);
        cfg_wr    = wr_en && (wr_be == 4'hF) && unlocked && (wr_off != OFF_CTRL);
        ctrl_wr   = wr_en && (wr_off == OFF_CTRL) && wr_be[0];
        start_try = en_q && go && req_q && !act_q && (cnt_q != '0);
        last_beat = beat_ok && act_q && (cnt_q == step_w);
        err_pulse = start_try && !aligned;
    end

    // Configuration registers: software writes when unlocked, beats when running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            sw_q   <= 1'b0;
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (cfg_wr) begin
                case (wr_off)
                    OFF_MODE: begin size_q <= wr_data[2:0]; sw_q <= wr_data[4]; end
                    OFF_SRC:  src_q <= wr_data;
                    OFF_DST:  dst_q <= wr_data;
                    OFF_CNT:  cnt_q <= wr_data;
                    default:  ;
                endcase
            end
            if (beat_ok && act_q) begin
                src_q <= src_q + step_w;
                dst_q <= dst_q + step_w;
                cnt_q <= cnt_q - step_w;
            end
        end
    end

    // Control state: enable, end-clear, request and active, later events win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            eclr_q <= 1'b0;
            req_q  <= 1'b0;
            act_q  <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                en_q <= wr_data[0];
                if (!act_q) eclr_q <= wr_data[1];
            end
            if (!sw_q) req_q <= hw_req;
            else if (ctrl_wr) req_q <= wr_data[2];
            if (start_try) begin
                if (aligned) begin
                    act_q <= 1'b1;
                    if (sw_q) req_q <= 1'b0;
                end else begin
                    en_q <= 1'b0;
                end
            end
            if (last_beat) begin
                act_q <= 1'b0;
                if (eclr_q) en_q <= 1'b0;
            end
        end
    end

    // Readback multiplexer for this channel's window.
    always_comb begin
        case (rd_off)
            OFF_MODE: rd_data = {{(REG_W-5){1'b0}}, sw_q, 1'b0, size_q};
            OFF_SRC:  rd_data = src_q;
            OFF_DST:  rd_data = dst_q;
            OFF_CNT:  rd_data = cnt_q;
            OFF_CTRL: rd_data = {{(REG_W-3){1'b0}}, req_q, eclr_q, en_q};
            default:  rd_data = '0;
        endcase
    end

    // Drive the channel outputs.
    always_comb begin
        active    = act_q;
        src_addr  = src_q;
        dst_addr  = dst_q;
        size_code = size_q;
    end

    // R6
    act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_q) |-> $past(en_q && go && req_q));

    // R4
    act_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> !act_q);

    // R4
    end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && eclr_q) |=> !en_q);

    // R3
    misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> (!act_q && !en_q));

    // R8
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_off == OFF_MODE) && !unlocked) |=> ($stable(size_q) && $stable(sw_q)));

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && act_q) |=> (cnt_q == $past(cnt_q) - $past(step_w)));
endmodule

// File: rtl/dma_ctl_unit.sv
// Top of the DMA front end: decodes the register port, holds the global
// start and sticky error words, instantiates the channels and routes the
// winning channel to the memory beat port. Assumes 2 <= NCH <= 4 (two
// channel-select address bits) and word-aligned register addresses.
module dma_ctl_unit
    import dma_ctl_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [3:0]       reg_be,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [NCH-1:0]   hw_req,
    output logic             mem_req,
    output logic [CHW-1:0]   mem_ch,
    output logic [REG_W-1:0] mem_src,
    output logic [REG_W-1:0] mem_dst,
    output logic [2:0]       mem_size,
    input  logic             mem_ack
);
    logic             go_q;
    logic [NCH-1:0]   err_q;
    logic [NCH-1:0]   act_v, err_set, grant;
    logic [REG_W-1:0] ch_rd  [NCH];
    logic [REG_W-1:0] ch_src [NCH];
    logic [REG_W-1:0] ch_dst [NCH];
    logic [2:0]       ch_sz  [NCH];
    logic             wr_ok, glb_sel, go_wr, err_wr;
    logic [NCH-1:0]   err_clr;
    logic [CHW-1:0]   gidx;
    logic             any_act;

    // Decode global writes.
    always_comb begin
        wr_ok   = reg_wr && (reg_addr[1:0] == 2'b00);
        glb_sel = reg_addr[7];
        go_wr   = wr_ok && glb_sel && (reg_addr[3:2] == GOFF_START) && reg_be[0];
        err_wr  = wr_ok && glb_sel && (reg_addr[3:2] == GOFF_ERR) && reg_be[0];
        err_clr = err_wr ? reg_wdata[NCH-1:0] : '0;
    end

    // Global start bit.
    always_ff @(posedge clk) begin
        if (!rst_n) go_q <= 1'b0;
        else if (go_wr) go_q <= reg_wdata[0];
    end

    // Sticky error flags: write-one-to-clear, new errors take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else err_q <= (err_q & ~err_clr) | err_set;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        // Decode this channel's register window.
        always_comb begin
            sel = wr_ok && !glb_sel && (reg_addr[6:5] == 2'(c));
        end

        dma_chan_core u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (sel),
            .wr_off    (reg_addr[4:2]),
            .wr_be     (reg_be),
            .wr_data   (reg_wdata),
            .go        (go_q),
            .hw_req    (hw_req[c]),
            .beat_ok   (mem_ack && grant[c]),
            .rd_off    (reg_addr[4:2]),
            .rd_data   (ch_rd[c]),
            .active    (act_v[c]),
            .err_pulse (err_set[c]),
            .src_addr  (ch_src[c]),
            .dst_addr  (ch_dst[c]),
            .size_code (ch_sz[c])
        );
    end

    dma_beat_arb #(.NCH(NCH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (act_v),
        .grant (grant),
        .idx   (gidx),
        .any   (any_act)
    );

    // Route the winning channel to the memory beat port.
    always_comb begin
        mem_req  = any_act;
        mem_ch   = gidx;
        mem_src  = ch_src[gidx];
        mem_dst  = ch_dst[gidx];
        mem_size = ch_sz[gidx];
    end

    // Register readback multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (glb_sel) begin
            case (reg_addr[3:2])
                GOFF_START:  reg_rdata = {{(REG_W-1){1'b0}}, go_q};
                GOFF_STATUS: reg_rdata = {{(REG_W-NCH){1'b0}}, act_v};
                GOFF_ERR:    reg_rdata = {{(REG_W-NCH){1'b0}}, err_q};
                default:     reg_rdata = '0;
            endcase
        end else if (int'(reg_addr[6:5]) < NCH) begin
            reg_rdata = ch_rd[reg_addr[6:5]];
        end
    end

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_set == '0) && !err_wr) |=> $stable(err_q));

    // R7
    err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != '0) |=> ((err_q & $past(err_set)) == $past(err_set)));

    // R10
    beat_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> act_v[mem_ch]);
endmodule

// File: tb/tb_dma_ctl_unit.sv
module tb_dma_ctl_unit;
    localparam int NCH = 4;
    localparam real HALF = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  hw_req = '0;
    logic        mem_req;
    logic [1:0]  mem_ch;
    logic [31:0] mem_src, mem_dst;
    logic [2:0]  mem_size;
    logic        mem_ack = 1'b0;

    int errors = 0;
    int checks = 0;

    always #(HALF) clk = ~clk;

    dma_ctl_unit #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_req(hw_req), .mem_req(mem_req), .mem_ch(mem_ch),
        .mem_src(mem_src), .mem_dst(mem_dst), .mem_size(mem_size),
        .mem_ack(mem_ack)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [2:0]  sz;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] cnt;
        logic        eclr;
        logic        bad;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 3'b000, 32'h0000_1001, 32'h0000_2003, 32'd5,  1'b1, 1'b0},
        '{2'd1, 3'b001, 32'h0000_0100, 32'h0000_0202, 32'd6,  1'b0, 1'b0},
        '{2'd2, 3'b010, 32'h0000_0400, 32'h0000_0800, 32'd16, 1'b1, 1'b0},
        '{2'd3, 3'b010, 32'h0000_0402, 32'h0000_0800, 32'd8,  1'b1, 1'b1},
        '{2'd1, 3'b001, 32'h0000_0100, 32'h0000_0200, 32'd7,  1'b0, 1'b1},
        '{2'd0, 3'b011, 32'h0000_0100, 32'h0000_0200, 32'd8,  1'b1, 1'b1},
        '{2'd3, 3'b001, 32'h0000_0100, 32'h0000_0201, 32'd4,  1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] cb(input int ch, input int off);
        return 8'(ch * 32 + off);
    endfunction

    int beats;
    logic [31:0] v;

    task automatic run_beats(input int n);
        beats = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (mem_req) beats++;
        end
    endtask

    initial begin
        #(HALF * 2 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h84, v); chk("R1 status after reset", v, 0);
        rd(8'h88, v); chk("R1 error after reset", v, 0);
        rd(cb(0, 0), v); chk("R1 mode after reset", v, 0);
        rd(cb(2, 16), v); chk("R1 ctrl after reset", v, 0);
        chk("R1 mem_req after reset", {31'b0, mem_req}, 0);

        wr(8'h80, 32'h1, 4'hF);

        // table walk: R2 R3 R4 R6
        foreach (VECS[i]) begin
            vec_t t;
            int st;
            int c;
            t = VECS[i];
            c = int'(t.ch);
            st = (t.sz == 3'b000) ? 1 : (t.sz == 3'b001) ? 2 : 4;
            wr(cb(c, 0),  {29'b0, t.sz}, 4'hF);
            wr(cb(c, 4),  t.src, 4'hF);
            wr(cb(c, 8),  t.dst, 4'hF);
            wr(cb(c, 12), t.cnt, 4'hF);
            wr(cb(c, 16), {30'b0, t.eclr, 1'b1}, 4'hF);
            @(negedge clk);
            hw_req[c] = 1'b1; mem_ack = 1'b1;
            run_beats(40);
            hw_req = '0; mem_ack = 1'b0;
            if (t.bad) begin
                chk("R3 no beats on misaligned start", beats, 0);
                rd(8'h88, v); chk("R3 error flag set", v, 32'(1 << c));
                rd(cb(c, 16), v); chk("R3 enable cleared", v & 1, 0);
                wr(8'h88, 32'(1 << c), 4'hF);
                rd(8'h88, v); chk("R7 error cleared by one", v, 0);
            end else begin
                chk("R4 beat count", beats, int'(t.cnt) / st);
                rd(cb(c, 4), v);  chk("R2 source advanced", v, t.src + t.cnt);
                rd(cb(c, 8), v);  chk("R2 destination advanced", v, t.dst + t.cnt);
                rd(cb(c, 12), v); chk("R2 count reached zero", v, 0);
                rd(cb(c, 16), v); chk("R4 enable after end", v & 1, t.eclr ? 0 : 1);
                rd(8'h84, v);     chk("R6 status low after end", v, 0);
                rd(8'h88, v);     chk("R3 no error on aligned", v, 0);
            end
            wr(cb(c, 16), 32'h0, 4'hF);
        end

        // R8 write lock
        wr(cb(3, 4), 32'h40, 4'hF);
        rd(cb(3, 4), v); chk("R8 write while disabled", v, 32'h40);
        wr(cb(3, 16), 32'h1, 4'hF);
        wr(cb(3, 4), 32'h80, 4'hF);
        rd(cb(3, 4), v); chk("R8 write ignored when enabled and started", v, 32'h40);
        wr(8'h80, 32'h0, 4'hF);
        wr(cb(3, 4), 32'h80, 4'hF);
        rd(cb(3, 4), v); chk("R8 write accepted with start off", v, 32'h80);
        wr(8'h80, 32'h1, 4'hF);
        wr(cb(3, 16), 32'h0, 4'hF);

        // R9 partial write
        wr(cb(3, 4), 32'hFFFF, 4'h3);
        rd(cb(3, 4), v); chk("R9 partial write ignored", v, 32'h80);

        // R5 hardware request mode
        @(negedge clk); hw_req[1] = 1'b1;
        repeat (2) @(negedge clk);
        rd(cb(1, 16), v); chk("R5 request follows hw", (v >> 2) & 1, 1);
        @(negedge clk); hw_req[1] = 1'b0;
        wr(cb(1, 16), 32'h4, 4'hF);
        rd(cb(1, 16), v); chk("R5 software write ignored in hw mode", (v >> 2) & 1, 0);
        wr(cb(1, 16), 32'h0, 4'hF);

        // R5 software trigger mode
        wr(cb(2, 0), 32'h10, 4'hF);
        wr(cb(2, 4), 32'h0, 4'hF);
        wr(cb(2, 8), 32'h10, 4'hF);
        wr(cb(2, 12), 32'd3, 4'hF);
        @(negedge clk); hw_req[2] = 1'b1;
        repeat (2) @(negedge clk);
        rd(cb(2, 16), v); chk("R5 hw ignored in sw mode", (v >> 2) & 1, 0);
        @(negedge clk); mem_ack = 1'b1;
        wr(cb(2, 16), 32'h5, 4'hF);
        run_beats(30);
        mem_ack = 1'b0; hw_req = '0;
        chk("R5 sw triggered beats", beats, 3);
        rd(cb(2, 16), v); chk("R5 request consumed at start", v, 32'h1);
        wr(cb(2, 16), 32'h0, 4'hF);

        // R10 priority between two active channels
        for (int c = 0; c < 2; c++) begin
            wr(cb(c, 0), 32'h0, 4'hF);
            wr(cb(c, 4), 32'h100 * (c + 1), 4'hF);
            wr(cb(c, 8), 32'h900, 4'hF);
            wr(cb(c, 12), 32'd2, 4'hF);
            wr(cb(c, 16), 32'h3, 4'hF);
        end
        @(negedge clk); hw_req = 4'b0011;
        repeat (3) @(negedge clk);
        rd(8'h84, v); chk("R10 both active", v, 32'h3);
        chk("R10 lowest channel owns port", {30'b0, mem_ch}, 0);
        chk("R10 port shows channel 0 source", mem_src, 32'h100);
        @(negedge clk); mem_ack = 1'b1;
        @(negedge clk);
        rd(cb(1, 12), v); chk("R10 channel 1 waits", v, 2);
        run_beats(20);
        mem_ack = 1'b0; hw_req = '0;
        rd(8'h84, v); chk("R10 both finished", v, 0);
        rd(cb(1, 12), v); chk("R10 channel 1 drained", v, 0);

        // R7 write-one-to-clear on two flags
        for (int c = 0; c < 4; c += 3) begin
            wr(cb(c, 0), 32'h1, 4'hF);
            wr(cb(c, 4), 32'h101, 4'hF);
            wr(cb(c, 12), 32'd2, 4'hF);
            wr(cb(c, 16), 32'h1, 4'hF);
        end
        @(negedge clk); hw_req = 4'b1001;
        repeat (3) @(negedge clk);
        hw_req = '0;
        rd(8'h88, v); chk("R7 two flags set", v, 32'h9);
        wr(8'h88, 32'h0, 4'hF);
        rd(8'h88, v); chk("R7 zero write keeps flags", v, 32'h9);
        wr(8'h88, 32'h1, 4'hF);
        rd(8'h88, v); chk("R7 clears only channel 0", v, 32'h8);
        wr(8'h88, 32'h8, 4'hF);
        rd(8'h88, v); chk("R7 clears channel 3", v, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule